// File: doc/BRIEF.md
# Composable 8-bit ALU Datapath with Carry Flag

This block is the arithmetic core of a two-address machine that has no opcode field. Every operation is built from a handful of independent control bits taken from the upper 16 bits of the instruction word. The bits are:
- a source select for operand A (memory byte or the instruction's own A byte),
- a ones-complementer on A,
- a zero-forcing gate on B,
- a carry-in source,
- an AND mode,
- a one-bit right-shift mode.

Addition, reverse subtraction, subtract-with-borrow, negation, complement, move, bit-clear, shifts and rotates all arise from combinations of these bits.

The result and carry-out are combinational functions of the current control word, the operands and the stored carry flag. A single carry flag register loads the carry-out on every cycle in which `exec_en` is high. The surrounding machine owns memory, fetch, branching and I/O. It reads `result` and `carry_out` in the same cycle it presents the operands, and it pulses `exec_en` once per executed instruction.

The datapath has no stream interface. Operands come in and results go out in the same cycle, with no back-pressure. Every pin is a plain control or data pin.

Top module: `relay_alu_core`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `carry_flag` to 0, even when `exec_en` is high in the same cycle.
- R2: Control bit 14 selects operand A. When it is 1, A is `a_byte`; when it is 0, A is `a_mem`.
- R3: Control bit 6 inverts every bit of operand A before use. B is never inverted.
- R4: Control bit 7 enables operand B. When it is 0, B is forced to zero; when it is 1, B is `b_mem`.
- R5: Control bit 4 makes the carry-in equal to `carry_flag`, and control bit 5 makes it 1. The carry-in is the OR of the two terms, so with both bits set it is 1, and with neither set it is 0.
- R6: When bits 8 and 9 are both 0, `{carry_out, result}` is the 9-bit sum A' + B' + carry-in. Here A' and B' are the operands after R2 to R4.
- R7: When bit 8 is 1 and bit 9 is 0 (AND mode), `result` is A' AND B', and `carry_out` is 0.
- R8: When bit 9 is 1 (shift right), `result` is {carry-in, A'[7:1]} and `carry_out` is A'[0]. This mode takes precedence over AND mode.
- R9: On a rising edge with `exec_en` high and `rst` low, `carry_flag` takes `carry_out`. With `exec_en` low, it holds its value.
- R10: Control bits 15, 13 to 10 and 3 to 0 have no effect on `result`, `carry_out` or `carry_flag`.
- R11: The word 0x4010 with `a_byte` = 0xFF leaves `carry_flag` unchanged after execution. This is immediate A, no complement, B zeroed, carry-in from the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the carry flag updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| exec_en | input | 1 | High for one cycle per executed instruction; loads the carry flag |
| ctl_word | input | 16 | Upper half of the instruction word holding the control bits |
| a_byte | input | 8 | A byte of the instruction, used as immediate data |
| a_mem | input | 8 | Memory byte addressed by the A field |
| b_mem | input | 8 | Memory byte addressed by the B field |
| result | output | 8 | ALU result |
| carry_out | output | 1 | ALU carry-out |
| carry_flag | output | 1 | Stored carry flag |

## Verification
The bound assertions watch the carry flag on every cycle:
- it must load the carry-out when `exec_en` is high;
- it must hold when `exec_en` is low;
- it must read zero after a reset cycle.

They also check, on every cycle, the properties that hold whatever the operands are:
- AND mode never produces a carry;
- a right shift sends A'[0] out and the shifted bits into the result;
- a plain move with no complement, no B and no carry-in returns A unchanged.

The actual arithmetic of each control combination needs the bench's sweep. It covers every listed encoding over all 256 values of A, several B values and both starting carry values, against an arithmetic reference. Only that sweep can show subtraction, negation, rotation, the carry-in OR and the ignored control bits.

// File: rtl/relay_alu_pkg.sv
package relay_alu_pkg;

  // Bit positions inside the 16-bit control word (neighbours decode these).
  localparam int CinFlagBit = 4;
  localparam int CinOneBit  = 5;
  localparam int CompABit   = 6;
  localparam int EnBBit     = 7;
  localparam int AndBit     = 8;
  localparam int ShrBit     = 9;
  localparam int ImmBit     = 14;

  typedef struct packed {
    logic imm_a;
    logic comp_a;
    logic en_b;
    logic cin_flag;
    logic cin_one;
    logic and_mode;
    logic shr_mode;
  } alu_ctl_t;

endpackage

// File: rtl/relay_alu_operands.sv
module relay_alu_operands #(
  parameter int DATA_W = 8
) (
  input  logic              imm_a,
  input  logic              comp_a,
  input  logic              en_b,
  input  logic [DATA_W-1:0] a_byte,
  input  logic [DATA_W-1:0] a_mem,
  input  logic [DATA_W-1:0] b_mem,
  output logic [DATA_W-1:0] a_op,
  output logic [DATA_W-1:0] b_op
);

  logic [DATA_W-1:0] a_src;

  assign a_src = imm_a ? a_byte : a_mem;

  // One complementer stage per bit on A, one gating stage per bit on B.
  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    assign a_op[g] = a_src[g] ^ comp_a;
    assign b_op[g] = b_mem[g] & en_b;
  end

endmodule

// File: rtl/relay_alu_cin_sel.sv
module relay_alu_cin_sel (
  input  logic cin_flag,
  input  logic cin_one,
  input  logic flag_q,
  output logic cin
);

  // Both sources may be requested; the forced one dominates.
  assign cin = (cin_flag & flag_q) | cin_one;

endmodule

// File: rtl/relay_alu_compute.sv
module relay_alu_compute #(
  parameter int DATA_W = 8
) (
  input  logic              and_mode,
  input  logic              shr_mode,
  input  logic [DATA_W-1:0] a_op,
  input  logic [DATA_W-1:0] b_op,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);

  logic [DATA_W:0]   chain;
  logic [DATA_W-1:0] sum;

  assign chain[0] = cin;

  // Ripple chain of full adders.
  for (genvar g = 0; g < DATA_W; g++) begin : g_fa
    logic prop;
    assign prop       = a_op[g] ^ b_op[g];
    assign sum[g]     = prop ^ chain[g];
    assign chain[g+1] = (a_op[g] & b_op[g]) | (chain[g] & prop);
  end

  always_comb begin
    if (shr_mode) begin
      res  = {cin, a_op[DATA_W-1:1]};
      cout = a_op[0];
    end else if (and_mode) begin
      res  = a_op & b_op;
      cout = 1'b0;
    end else begin
      res  = sum;
      cout = chain[DATA_W];
    end
  end

endmodule

// File: rtl/relay_alu_core.sv
module relay_alu_core
  import relay_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CTL_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exec_en,
  input  logic [CTL_W-1:0]  ctl_word,
  input  logic [DATA_W-1:0] a_byte,
  input  logic [DATA_W-1:0] a_mem,
  input  logic [DATA_W-1:0] b_mem,
  output logic [DATA_W-1:0] result,
  output logic              carry_out,
  output logic              carry_flag
);

  alu_ctl_t          ctl;
  logic [DATA_W-1:0] a_op;
  logic [DATA_W-1:0] b_op;
  logic              cin;

  assign ctl.imm_a    = ctl_word[ImmBit];
  assign ctl.comp_a   = ctl_word[CompABit];
  assign ctl.en_b     = ctl_word[EnBBit];
  assign ctl.cin_flag = ctl_word[CinFlagBit];
  assign ctl.cin_one  = ctl_word[CinOneBit];
  assign ctl.and_mode = ctl_word[AndBit];
  assign ctl.shr_mode = ctl_word[ShrBit];

  relay_alu_operands #(.DATA_W(DATA_W)) u_operands (
    .imm_a  (ctl.imm_a),
    .comp_a (ctl.comp_a),
    .en_b   (ctl.en_b),
    .a_byte (a_byte),
    .a_mem  (a_mem),
    .b_mem  (b_mem),
    .a_op   (a_op),
    .b_op   (b_op)
  );

  relay_alu_cin_sel u_cin_sel (
    .cin_flag (ctl.cin_flag),
    .cin_one  (ctl.cin_one),
    .flag_q   (carry_flag),
    .cin      (cin)
  );

  relay_alu_compute #(.DATA_W(DATA_W)) u_compute (
    .and_mode (ctl.and_mode),
    .shr_mode (ctl.shr_mode),
    .a_op     (a_op),
    .b_op     (b_op),
    .cin      (cin),
    .res      (result),
    .cout     (carry_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_flag <= 1'b0;
    end else if (exec_en) begin
      carry_flag <= carry_out;
    end
  end

endmodule

// File: rtl/relay_alu_core_checker.sv
module relay_alu_core_checker
  import relay_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CTL_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              exec_en,
  input logic [CTL_W-1:0]  ctl_word,
  input logic [DATA_W-1:0] a_byte,
  input logic [DATA_W-1:0] a_mem,
  input logic [DATA_W-1:0] result,
  input logic              carry_out,
  input logic              carry_flag
);

  logic [DATA_W-1:0] a_sel;
  logic              rst_q;
  logic              plain_move;

  assign a_sel = ctl_word[ImmBit] ? a_byte : a_mem;
  assign plain_move = !ctl_word[EnBBit] && !ctl_word[CompABit] && !ctl_word[AndBit]
                   && !ctl_word[ShrBit] && !ctl_word[CinFlagBit] && !ctl_word[CinOneBit];

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q) begin
      AST_RESET_CLEARS_FLAG: assert (!carry_flag); // R1
    end
  end

  AST_FLAG_LOADS: assert property (@(posedge clk) disable iff (rst)
    exec_en |=> carry_flag == $past(carry_out)); // R9

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !exec_en |=> $stable(carry_flag)); // R9

  AST_AND_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
    (ctl_word[AndBit] && !ctl_word[ShrBit]) |-> !carry_out); // R7

  AST_SHR_OUT_BIT: assert property (@(posedge clk) disable iff (rst)
    ctl_word[ShrBit] |-> (carry_out == (a_sel[0] ^ ctl_word[CompABit]))); // R8

  AST_SHR_BODY: assert property (@(posedge clk) disable iff (rst)
    (ctl_word[ShrBit] && !ctl_word[CompABit])
      |-> result[DATA_W-2:0] == a_sel[DATA_W-1:1]); // R8

  AST_PLAIN_MOVE: assert property (@(posedge clk) disable iff (rst)
    plain_move |-> (result == a_sel && !carry_out)); // R4

  AST_CTL_DEFINED: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(ctl_word)); // R10

endmodule

bind relay_alu_core relay_alu_core_checker #(.DATA_W(DATA_W), .CTL_W(CTL_W)) u_checker (
  .clk        (clk),
  .rst        (rst),
  .exec_en    (exec_en),
  .ctl_word   (ctl_word),
  .a_byte     (a_byte),
  .a_mem      (a_mem),
  .result     (result),
  .carry_out  (carry_out),
  .carry_flag (carry_flag)
);

// File: tb/relay_alu_core_bench.sv
module relay_alu_core_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        exec_en;
  logic [15:0] ctl_word;
  logic [7:0]  a_byte;
  logic [7:0]  a_mem;
  logic [7:0]  b_mem;
  logic [7:0]  result;
  logic        carry_out;
  logic        carry_flag;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  localparam int NOPS = 30;
  localparam logic [15:0] OPS [NOPS] = '{
    16'h0880, 16'h4880, 16'h0890, 16'h4890, 16'h08A0, 16'h0A00, 16'h0A20, 16'h0A10,
    16'h0080, 16'h08E0, 16'h48E0, 16'h08D0, 16'h48D0, 16'h0980, 16'h4980, 16'h09C0,
    16'h49C0, 16'h0860, 16'h0850, 16'h0840, 16'h0800, 16'h4800, 16'h4010, 16'h4020,
    16'h0000, 16'h802A, 16'h0061, 16'h0300, 16'h0030, 16'h3C8F
  };
  localparam logic [7:0] BVALS [5] = '{8'h00, 8'h01, 8'h5A, 8'h80, 8'hFF};

  always #4 clk = ~clk;

  relay_alu_core u_relay_alu_core (
    .clk        (clk),
    .rst        (rst),
    .exec_en    (exec_en),
    .ctl_word   (ctl_word),
    .a_byte     (a_byte),
    .a_mem      (a_mem),
    .b_mem      (b_mem),
    .result     (result),
    .carry_out  (carry_out),
    .carry_flag (carry_flag)
  );

  // Reference built from the requirements: returns {carry_out, result}.
  function automatic logic [8:0] ref_alu(input logic [15:0] w, input logic [7:0] ab,
                                         input logic [7:0] am, input logic [7:0] bm,
                                         input logic c);
    logic [7:0] a;
    logic [7:0] b;
    logic       ci;
    a  = w[14] ? ab : am;                 // R2
    if (w[6]) a = 8'hFF - a;              // R3
    b  = w[7] ? bm : 8'h00;               // R4
    ci = (w[4] && c) || w[5];             // R5
    if (w[9])      return {a[0], ci, a[7:1]};           // R8
    else if (w[8]) return {1'b0, a & b};                // R7
    else           return 9'(a) + 9'(b) + 9'(ci);       // R6
  endfunction

  function automatic string tag_of(input logic [15:0] w);
    if (w == 16'h4010)               return "R11";
    if ((w & 16'hBC0F) != 16'h0000) return "R10";
    if (w[9])                        return "R8";
    if (w[8])                        return "R7";
    if (w[4] && w[5])                return "R5";
    if (w[14])                       return "R2";
    if (w[6])                        return "R3";
    if (!w[7])                       return "R4";
    return "R6";
  endfunction

  task automatic note(input bit ok, input string tag, input string what,
                      input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Entered at a falling edge; leaves at a falling edge two cycles later.
  task automatic run_vec(input logic [15:0] w, input logic [7:0] ab, input logic [7:0] am,
                         input logic [7:0] bm, input logic c);
    logic [8:0] exp;
    string      tag;
    bit         ok;
    // set the flag: 0x4020 with a_byte FF yields carry 1; 0x0000 with a_mem 0 yields 0
    ctl_word = c ? 16'h4020 : 16'h0000;
    a_byte   = 8'hFF;
    a_mem    = 8'h00;
    b_mem    = 8'h00;
    exec_en  = 1'b1;
    @(negedge clk);
    ctl_word = w;
    a_byte   = ab;
    a_mem    = am;
    b_mem    = bm;
    exp      = ref_alu(w, ab, am, bm, c);
    tag      = tag_of(w);
    #1;
    ok = (result == exp[7:0]) && (carry_out == exp[8]) && (carry_flag == c);
    @(negedge clk);
    ok = ok && (carry_flag == exp[8]);    // R9 load
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s op %h a_byte %h a_mem %h b %h c %0d: actual res %h co %0d flag %0d expected res %h co %0d",
               tag, w, ab, am, bm, c, result, carry_out, carry_flag, exp[7:0], exp[8]);
    end
  endtask

  initial begin
    rst      = 1'b1;
    exec_en  = 1'b1;
    ctl_word = 16'h4020;
    a_byte   = 8'hFF;
    a_mem    = 8'h00;
    b_mem    = 8'h00;
    repeat (3) @(negedge clk);
    note(carry_flag == 1'b0, "R1", "flag under reset with carry-setting op", carry_flag, 0);

    rst = 1'b0;
    @(negedge clk);
    note(carry_flag == 1'b1, "R9", "flag after carry-setting op", carry_flag, 1);

    // R9: hold with exec_en low while a clearing op is presented
    exec_en  = 1'b0;
    ctl_word = 16'h0000;
    repeat (3) @(negedge clk);
    note(carry_flag == 1'b1, "R9", "flag held with exec_en low", carry_flag, 1);

    // R1: reset overrides a load in the same cycle
    exec_en  = 1'b1;
    ctl_word = 16'h4020;
    rst      = 1'b1;
    @(negedge clk);
    note(carry_flag == 1'b0, "R1", "reset wins over exec_en", carry_flag, 0);
    rst = 1'b0;

    // R9: hold at zero while a setting op is presented
    exec_en = 1'b0;
    repeat (2) @(negedge clk);
    note(carry_flag == 1'b0, "R9", "zero flag held with exec_en low", carry_flag, 0);

    // Sweep: every encoding, all A values, several B values, both carry values
    for (int k = 0; k < NOPS; k++) begin
      for (int ci = 0; ci < 2; ci++) begin
        for (int bi = 0; bi < 5; bi++) begin
          for (int av = 0; av < 256; av++) begin
            run_vec(OPS[k], 8'(av) ^ 8'hA5, 8'(av), BVALS[bi], 1'(ci));
          end
        end
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule